// File: doc/BRIEF.md
# Peripheral Bus Write Latch

This block sits between a CPU-side request port and a slow parallel peripheral bus. A CPU write that arrives while the bus is idle is taken into a 32-bit holding register and sent out on the back-side port. The block then raises an I/O-busy flag and runs a countdown of `LATENCY` cycles. Further writes are discarded until the countdown ends. One exception is a byte write to a single debug address: it still goes out on the bus, but the holding register keeps its value.

A read that arrives while the flag is up does not touch the bus. It is answered at once with bits taken from the held word. The same read ends the busy period early and emits a one-cycle stall report, which gives the number of countdown cycles that were left. A read on an idle bus goes out on the back side as a normal transaction, and its data is returned, trimmed to the access size. The back side uses a single request/acknowledge pair. Only one transaction is outstanding at a time.

Top module: `pbus_wlatch`

## Requirements
- R1: After reset `busy_o`, `bus_req_o`, `stall_valid_o` and `rsp_valid_o` are low and `req_ready_o` is high. A reset during a busy period clears `busy_o`.
- R2: A write accepted while `busy_o` is low issues one back-side write carrying the request's own address, size and unshifted data. `busy_o` rises after the accepting edge and clears by itself after exactly `LATENCY` edges if no read intervenes.
- R3: A write accepted while `busy_o` is high, other than the debug case of R8, starts no back-side transaction and leaves the held word unchanged.
- R4: Size encoding is 0 byte, 1 halfword, 2 word, 3 doubleword. A byte write is held in bits 31:24 when address bit 0 is 0 and in bits 23:16 when it is 1. A halfword is held in 31:16 and a word in 31:0. A doubleword keeps only its bits 63:32. All other held bits become zero.
- R5: A read accepted while busy is answered on the next cycle without a bus transaction. A byte read returns held bits 31:24, a halfword read returns 31:16 and a word read returns the whole held word, each zero-extended. A doubleword read returns the held word in bits 63:32 with zeros below.
- R6: A read accepted while busy clears `busy_o` on the same edge. It also drives `stall_valid_o` high for exactly one cycle, with `stall_cycles_o` equal to the countdown value present at that edge; a read k edges after the write edge reports `LATENCY+1-k`.
- R7: `stall_cycles_o` saturates at `STALL_MAX` and is never zero while valid.
- R8: A byte write to `DBG_ADDR` accepted while busy is still issued as a back-side write, while the held word and `busy_o` are left as they were.
- R9: A read accepted while idle issues a back-side read. Its response returns `bus_rdata_i` masked to the access size (low 8, 16, 32 or all 64 bits), and it raises no stall report.
- R10: `req_ready_o` is low whenever a back-side transaction is outstanding (`bus_req_o` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | CPU request present |
| req_ready_o | output | 1 | Request taken on this edge when high |
| req_write_i | input | 1 | 1 write, 0 read |
| req_size_i | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 doubleword |
| req_addr_i | input | AW | Request address |
| req_wdata_i | input | 2*LW | Write data, right-aligned |
| rsp_valid_o | output | 1 | Read response strobe |
| rsp_rdata_o | output | 2*LW | Read response data |
| busy_o | output | 1 | I/O busy flag |
| stall_valid_o | output | 1 | One-cycle stall report strobe |
| stall_cycles_o | output | $clog2(STALL_MAX+1) | Remaining cycles, saturated |
| bus_req_o | output | 1 | Back-side request, held until acknowledge |
| bus_we_o | output | 1 | Back-side write enable |
| bus_size_o | output | 2 | Back-side access size |
| bus_addr_o | output | AW | Back-side address |
| bus_wdata_o | output | 2*LW | Back-side write data |
| bus_ack_i | input | 1 | Back-side acknowledge |
| bus_rdata_i | input | 2*LW | Back-side read data, valid with acknowledge |

## Verification
The properties assume a well-behaved back side: `bus_ack_i` is raised only while `bus_req_o` is high, and it is dropped after one cycle. They also assume the request fields are stable for the cycle in which `req_valid_i` is sampled. The bench's bus responder acknowledges only a request it can see, after a programmable delay, and it releases the acknowledge on the following cycle. CPU requests are driven only while `req_ready_o` is high, so every request is taken on the edge that follows it, and the remaining-cycle counts can be predicted from edge counting alone.

// File: rtl/pbwl_pkg.sv
package pbwl_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } xfer_size_e;
endpackage

// File: rtl/pbwl_lanes.sv
module pbwl_lanes
  import pbwl_pkg::*;
#(
  parameter int LW = 32
) (
  input  logic [1:0]      size_i,
  input  logic            addr_lsb_i,
  input  logic [2*LW-1:0] wdata_i,
  input  logic [LW-1:0]   held_i,
  output logic [LW-1:0]   pack_o,
  output logic [2*LW-1:0] view_o
);
  localparam int DW = 2 * LW;

  // write placement into the held word
  always_comb begin
    unique case (size_i)
      SZ_BYTE:  pack_o = addr_lsb_i ? (LW'(wdata_i[7:0]) << (LW - 16))
                                    : (LW'(wdata_i[7:0]) << (LW - 8));
      SZ_HALF:  pack_o = LW'(wdata_i[15:0]) << (LW - 16);
      SZ_WORD:  pack_o = wdata_i[LW-1:0];
      default:  pack_o = wdata_i[DW-1:LW];
    endcase
  end

  // read view of the held word
  always_comb begin
    unique case (size_i)
      SZ_BYTE:  view_o = DW'(held_i[LW-1 -: 8]);
      SZ_HALF:  view_o = DW'(held_i[LW-1 -: 16]);
      SZ_WORD:  view_o = DW'(held_i);
      default:  view_o = {held_i, {LW{1'b0}}};
    endcase
  end
endmodule

// File: rtl/pbwl_timer.sv
module pbwl_timer #(
  parameter int LATENCY   = 100,
  parameter int STALL_MAX = 100,
  localparam int CW = $clog2(LATENCY + 1),
  localparam int SW = $clog2(STALL_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          cancel_i,
  output logic          busy_o,
  output logic          stall_valid_o,
  output logic [SW-1:0] stall_cycles_o
);
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          stv_q;
  logic [SW-1:0] stc_q;
  logic [SW-1:0] sat_cnt;

  always_comb begin
    if (int'(cnt_q) > STALL_MAX) sat_cnt = SW'(STALL_MAX);
    else                         sat_cnt = SW'(cnt_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (arm_i) begin
      cnt_q  <= CW'(LATENCY);
      busy_q <= 1'b1;
    end else if (cancel_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stv_q <= 1'b0;
      stc_q <= '0;
    end else begin
      stv_q <= cancel_i;
      if (cancel_i) stc_q <= sat_cnt;
    end
  end

  assign busy_o         = busy_q;
  assign stall_valid_o  = stv_q;
  assign stall_cycles_o = stc_q;
endmodule

// File: rtl/pbwl_bus_port.sv
module pbwl_bus_port
  import pbwl_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          we_i,
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          pend_o,
  output logic          rd_done_o,
  output logic [DW-1:0] rd_data_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [1:0]    bus_size_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic          bus_ack_i,
  input  logic [DW-1:0] bus_rdata_i
);
  logic          req_q, we_q;
  logic [1:0]    size_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      size_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start_i) begin
      req_q   <= 1'b1;
      we_q    <= we_i;
      size_q  <= size_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end else if (req_q && bus_ack_i) begin
      req_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (size_q)
      SZ_BYTE:  rd_data_o = DW'(bus_rdata_i[7:0]);
      SZ_HALF:  rd_data_o = DW'(bus_rdata_i[15:0]);
      SZ_WORD:  rd_data_o = DW'(bus_rdata_i[31:0]);
      default:  rd_data_o = bus_rdata_i;
    endcase
  end

  assign rd_done_o   = req_q & bus_ack_i & ~we_q;
  assign pend_o      = req_q;
  assign bus_req_o   = req_q;
  assign bus_we_o    = we_q;
  assign bus_size_o  = size_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
endmodule

// File: rtl/pbus_wlatch.sv
module pbus_wlatch
  import pbwl_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          LW        = 32,
  parameter int          LATENCY   = 100,
  parameter int          STALL_MAX = 100,
  parameter logic [31:0] DBG_ADDR  = 32'h0500_0020,
  localparam int DW = 2 * LW,
  localparam int SW = $clog2(STALL_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [1:0]    req_size_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          busy_o,
  output logic          stall_valid_o,
  output logic [SW-1:0] stall_cycles_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [1:0]    bus_size_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic          bus_ack_i,
  input  logic [DW-1:0] bus_rdata_i
);
  logic          pend, rd_done;
  logic [DW-1:0] rd_data;
  logic          busy;
  logic          accept, is_dbg;
  logic          wr_take, dbg_fwd, rd_held, rd_bus, start;
  logic [LW-1:0] held_q, pack;
  logic [DW-1:0] view;
  logic          rsp_v_q;
  logic [DW-1:0] rsp_d_q;

  assign accept  = req_valid_i & ~pend;
  assign is_dbg  = (req_size_i == SZ_BYTE) && (req_addr_i == AW'(DBG_ADDR));
  assign wr_take = accept &  req_write_i & ~busy;
  assign dbg_fwd = accept &  req_write_i &  busy & is_dbg;
  assign rd_held = accept & ~req_write_i &  busy;
  assign rd_bus  = accept & ~req_write_i & ~busy;
  assign start   = wr_take | dbg_fwd | rd_bus;

  pbwl_lanes #(.LW(LW)) u_lanes (
    .size_i    (req_size_i),
    .addr_lsb_i(req_addr_i[0]),
    .wdata_i   (req_wdata_i),
    .held_i    (held_q),
    .pack_o    (pack),
    .view_o    (view)
  );

  pbwl_timer #(.LATENCY(LATENCY), .STALL_MAX(STALL_MAX)) u_timer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .arm_i         (wr_take),
    .cancel_i      (rd_held),
    .busy_o        (busy),
    .stall_valid_o (stall_valid_o),
    .stall_cycles_o(stall_cycles_o)
  );

  pbwl_bus_port #(.AW(AW), .DW(DW)) u_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .we_i       (req_write_i),
    .size_i     (req_size_i),
    .addr_i     (req_addr_i),
    .wdata_i    (req_wdata_i),
    .pend_o     (pend),
    .rd_done_o  (rd_done),
    .rd_data_o  (rd_data),
    .bus_req_o  (bus_req_o),
    .bus_we_o   (bus_we_o),
    .bus_size_o (bus_size_o),
    .bus_addr_o (bus_addr_o),
    .bus_wdata_o(bus_wdata_o),
    .bus_ack_i  (bus_ack_i),
    .bus_rdata_i(bus_rdata_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      held_q <= '0;
    else if (wr_take) held_q <= pack;
  end

  // held-word reads and bus reads never complete on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_v_q <= 1'b0;
      rsp_d_q <= '0;
    end else begin
      rsp_v_q <= rd_held | rd_done;
      if (rd_held)      rsp_d_q <= view;
      else if (rd_done) rsp_d_q <= rd_data;
    end
  end

  assign req_ready_o = ~pend;
  assign rsp_valid_o = rsp_v_q;
  assign rsp_rdata_o = rsp_d_q;
  assign busy_o      = busy;
endmodule

// File: rtl/pbus_wlatch_chk.sv
module pbus_wlatch_chk #(
  parameter int          AW        = 32,
  parameter int          SW        = 7,
  parameter int          STALL_MAX = 100,
  parameter logic [31:0] DBG_ADDR  = 32'h0500_0020
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          req_write_i,
  input logic [1:0]    req_size_i,
  input logic [AW-1:0] req_addr_i,
  input logic          busy_o,
  input logic          stall_valid_o,
  input logic [SW-1:0] stall_cycles_o,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic          rsp_valid_o
);
  logic acc, dbg;
  assign acc = req_valid_i && req_ready_o;
  assign dbg = (req_size_i == 2'd0) && (req_addr_i == AW'(DBG_ADDR));

  p_arm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (bus_req_o && bus_we_o));

  p_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_write_i && busy_o && !dbg) |=> !bus_req_o);

  p_held_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !req_write_i && busy_o) |=> (rsp_valid_o && stall_valid_o && !bus_req_o));

  p_stall_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_valid_o |=> !stall_valid_o);

  p_stall_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_valid_o |-> !busy_o);

  p_stall_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_valid_o |-> (stall_cycles_o != '0 && int'(stall_cycles_o) <= STALL_MAX));

  p_dbg_fwd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_write_i && busy_o && dbg) |=> (bus_req_o && bus_we_o));

  p_idle_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !req_write_i && !busy_o) |=> (bus_req_o && !bus_we_o && !stall_valid_o));

  p_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> !req_ready_o);
endmodule

bind pbus_wlatch pbus_wlatch_chk #(
  .AW(AW), .SW(SW), .STALL_MAX(STALL_MAX), .DBG_ADDR(DBG_ADDR)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .req_write_i   (req_write_i),
  .req_size_i    (req_size_i),
  .req_addr_i    (req_addr_i),
  .busy_o        (busy_o),
  .stall_valid_o (stall_valid_o),
  .stall_cycles_o(stall_cycles_o),
  .bus_req_o     (bus_req_o),
  .bus_we_o      (bus_we_o),
  .rsp_valid_o   (rsp_valid_o)
);

// File: tb/pbus_wlatch_test.sv
`timescale 1ns/1ps
module pbus_wlatch_test;
  localparam logic [31:0] DBG = 32'h0500_0020;
  localparam logic [63:0] BUS_WORD = 64'h0123_4567_89AB_CDEF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        bus_ack = 1'b0;

  logic        ready, rsp_v, busy, st_v, b_req, b_we;
  logic [63:0] rsp_d, b_wd;
  logic [6:0]  st_c;
  logic [1:0]  b_sz;
  logic [31:0] b_ad;

  logic        rdy2, rspv2, busy2, stv2, breq2, bwe2;
  logic [63:0] rspd2, bwd2;
  logic [6:0]  stc2;
  logic [1:0]  bsz2;
  logic [31:0] bad2;

  int total = 0, bad = 0;
  int nwr = 0, ack_delay = 0, dly = 0;
  logic [31:0] last_addr = '0;
  logic [63:0] last_data = '0;
  logic [1:0]  last_size = '0;

  always #2.5 clk = ~clk;

  pbus_wlatch uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(ready), .req_write_i(req_write),
    .req_size_i(req_size), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_v), .rsp_rdata_o(rsp_d), .busy_o(busy),
    .stall_valid_o(st_v), .stall_cycles_o(st_c),
    .bus_req_o(b_req), .bus_we_o(b_we), .bus_size_o(b_sz), .bus_addr_o(b_ad),
    .bus_wdata_o(b_wd), .bus_ack_i(bus_ack), .bus_rdata_i(BUS_WORD)
  );

  // longer countdown, same saturation: exercises the clamp
  pbus_wlatch #(.LATENCY(150)) uut_sat (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(rdy2), .req_write_i(req_write),
    .req_size_i(req_size), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rspv2), .rsp_rdata_o(rspd2), .busy_o(busy2),
    .stall_valid_o(stv2), .stall_cycles_o(stc2),
    .bus_req_o(breq2), .bus_we_o(bwe2), .bus_size_o(bsz2), .bus_addr_o(bad2),
    .bus_wdata_o(bwd2), .bus_ack_i(breq2), .bus_rdata_i(64'd0)
  );

  // back-side responder
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack = 1'b0;
      dly = 0;
    end else if (b_req && !bus_ack) begin
      if (dly >= ack_delay) begin
        bus_ack = 1'b1;
        dly = 0;
        if (b_we) nwr++;
        last_addr = b_ad;
        last_data = b_wd;
        last_size = b_sz;
      end else dly++;
    end else bus_ack = 1'b0;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [1:0] sz, input logic [31:0] a, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_size = sz; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!ready) @(negedge clk);
  endtask

  task automatic cpu_rd(input logic [1:0] sz, input logic [31:0] a,
                        output logic [63:0] d, output bit sv, output int sc,
                        output bit sv2, output int sc2);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_size = sz; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    sv = 0; sc = 0; sv2 = 0; sc2 = 0; d = 'x;
    for (int i = 0; i < 20; i++) begin
      if (st_v) begin sv = 1; sc = int'(st_c); end
      if (stv2) begin sv2 = 1; sc2 = int'(stc2); end
      if (rsp_v) begin d = rsp_d; break; end
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic [1:0]  wsz;
    logic [31:0] waddr;
    logic [63:0] wdata;
    logic [1:0]  rsz;
    logic [63:0] exp;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{2'd0, 32'h1000_0000, 64'h0000_0000_0000_00A5, 2'd2, 64'h0000_0000_A500_0000},
    '{2'd0, 32'h1000_0001, 64'h0000_0000_0000_003C, 2'd1, 64'h0000_0000_0000_003C},
    '{2'd1, 32'h1000_0002, 64'h0000_0000_0000_BEEF, 2'd0, 64'h0000_0000_0000_00BE},
    '{2'd2, 32'h1000_0004, 64'h0000_0000_1234_5678, 2'd1, 64'h0000_0000_0000_1234},
    '{2'd3, 32'h1000_0008, 64'hCAFE_F00D_1122_3344, 2'd3, 64'hCAFE_F00D_0000_0000},
    '{2'd2, 32'h1000_000C, 64'h0000_0000_DEAD_BEEF, 2'd3, 64'hDEAD_BEEF_0000_0000}
  };

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] d;
    bit sv, sv2;
    int sc, sc2, n0;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 ready", ready, 1);
    check("R1 bus_req", b_req, 0);
    check("R1 stall_valid", st_v, 0);
    check("R1 rsp_valid", rsp_v, 0);
    rst_n = 1'b1;

    // R6/R7: read three edges after the write edge
    cpu_wr(2'd2, 32'h1000_0000, 64'h0000_0000_5555_AAAA);
    cpu_rd(2'd2, 32'h1000_0000, d, sv, sc, sv2, sc2);
    check("R5 word view", d, 64'h0000_0000_5555_AAAA);
    check("R6 stall seen", sv, 1);
    check("R6 stall count k=3", sc, 98);
    check("R7 saturated count", sc2, 100);
    check("R6 busy cleared", busy, 0);
    @(negedge clk);
    check("R6 single pulse", st_v, 0);

    // R6: count after extra idle cycles
    cpu_wr(2'd2, 32'h1000_0000, 64'h1);
    repeat (20) @(negedge clk);
    cpu_rd(2'd2, 32'h1000_0000, d, sv, sc, sv2, sc2);
    check("R6 stall count k=23", sc, 78);

    // R4/R5 vector table
    foreach (VEC[i]) begin
      cpu_wr(VEC[i].wsz, VEC[i].waddr, VEC[i].wdata);
      check("R2 busy after write", busy, 1);
      check("R2 bus write data", last_data, VEC[i].wdata);
      check("R2 bus write addr", 64'(last_addr), 64'(VEC[i].waddr));
      check("R2 bus write size", 64'(last_size), 64'(VEC[i].wsz));
      cpu_rd(VEC[i].rsz, VEC[i].waddr, d, sv, sc, sv2, sc2);
      check("R4 R5 held view", d, VEC[i].exp);
      check("R6 stall on held read", sv, 1);
    end

    // R3 dropped write
    cpu_wr(2'd2, 32'h1000_0010, 64'h1111_1111);
    n0 = nwr;
    cpu_wr(2'd2, 32'h1000_0010, 64'h2222_2222);
    @(negedge clk);
    check("R3 no bus write", 64'(nwr), 64'(n0));
    check("R3 bus idle", b_req, 0);
    cpu_rd(2'd2, 32'h1000_0010, d, sv, sc, sv2, sc2);
    check("R3 held word kept", d, 64'h1111_1111);

    // R8 debug byte forwarded while busy
    cpu_wr(2'd2, 32'h1000_0014, 64'h3333_3333);
    n0 = nwr;
    cpu_wr(2'd0, DBG, 64'h41);
    check("R8 forwarded", 64'(nwr), 64'(n0 + 1));
    check("R8 fwd addr", 64'(last_addr), 64'(DBG));
    check("R8 fwd data", last_data, 64'h41);
    check("R8 still busy", busy, 1);
    cpu_rd(2'd2, 32'h1000_0014, d, sv, sc, sv2, sc2);
    check("R8 held word kept", d, 64'h3333_3333);

    // R2 self expiry after LATENCY edges
    cpu_wr(2'd2, 32'h1000_0018, 64'h7);
    repeat (98) @(negedge clk);
    check("R2 busy at edge 99", busy, 1);
    @(negedge clk);
    check("R2 busy clear at edge 100", busy, 0);

    // R9 idle reads through the bus
    cpu_rd(2'd0, 32'h2000_0000, d, sv, sc, sv2, sc2);
    check("R9 byte", d, 64'hEF);
    check("R9 no stall", sv, 0);
    cpu_rd(2'd1, 32'h2000_0000, d, sv, sc, sv2, sc2);
    check("R9 half", d, 64'hCDEF);
    cpu_rd(2'd2, 32'h2000_0000, d, sv, sc, sv2, sc2);
    check("R9 word", d, 64'h89AB_CDEF);
    cpu_rd(2'd3, 32'h2000_0000, d, sv, sc, sv2, sc2);
    check("R9 dword", d, BUS_WORD);

    // R10 ready low while the bus is slow
    ack_delay = 3;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_size = 2'd2; req_addr = 32'h2000_0000;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 bus pending", b_req, 1);
    check("R10 ready low", ready, 0);
    @(negedge clk);
    check("R10 ready still low", ready, 0);
    while (!rsp_v) @(negedge clk);
    check("R10 slow read data", rsp_d, 64'h89AB_CDEF);
    ack_delay = 0;

    // R1 reset during busy
    cpu_wr(2'd2, 32'h1000_0000, 64'h9);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears busy", busy, 0);
    check("R1 reset bus idle", b_req, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule